// File: doc/BRIEF.md
# Bus-Mapped BCD Calendar Clock

This block is a calendar clock that a host sees as eight byte-wide registers at the highest eight addresses of a byte-addressed space. The host reaches them through a synchronous port with an address, write data, a write strobe, a read strobe and registered read data. A one-cycle pulse on `sec_tick` advances a set of hidden counters. These hold seconds, minutes, hours, day of week, date, month, year and a century flag, all in BCD. The hours count in 24-hour form.

The host never reads the counters directly. It reads user copies, and those copies are refreshed from the counters together, in the cycle after each tick. Setting the freeze bit in the control byte stops the refresh, so the host can read a consistent time while the counters keep running. Setting the load bit also stops the refresh, and clearing it copies the user time values into the counters in one step.

Three further bits are kept in the registers. A stop bit in the seconds byte suspends counting. A century bit inverts at the year wrap when its enable is set. A test bit places the `test_tick` square wave on bit 0 of a seconds read. The six low control bits hold a trim value, which the block stores and drives out on `trim_out` for a calibration stage elsewhere.

Top module: `rtc_bcd_regs`

## Requirements
- R1: The register at offset 0 of the top eight addresses (address with all upper bits set, low three bits 000) is control. Offsets 1 to 7 are seconds, minutes, hours, day, date, month and year. Read data appears on `bus_rdata` in the cycle after `bus_re`. A read of any other address returns 0x00.
- R2: Control bit 7 is LOAD and bit 6 is FREEZE. Bits 5:0 are a trim value that reads back as written and drives `trim_out`.
- R3: While LOAD and FREEZE are both 0, every user time register takes the counter value in the cycle after each `sec_tick` pulse.
- R4: While FREEZE is 1, the user time registers hold their values, and the counters keep advancing. After FREEZE is cleared, the next tick shows the counted time.
- R5: While LOAD is 1, refresh is held off. A write that clears LOAD copies the user seconds, minutes, hours, day, date, month, year and century bit into the counters.
- R6: Seconds bit 7 is STOP, and it resets to 1. While STOP is 1, a tick leaves the counters unchanged.
- R7: Seconds and minutes wrap from 59 to 00 and hours wrap from 23 to 00, each carrying into the next field with BCD digit carries. Day of week (day bits 2:0) steps from 7 to 1 at midnight.
- R8: The date wraps to 01 after the last day of the month: 30 for months 04, 06, 09 and 11, 31 for the other months, and 28 for February, or 29 when the year is a multiple of 4 (00 counts as one). The month wraps from 12 to 01.
- R9: The year wraps from 99 to 00. Day bit 5 (century enable) and day bit 4 (century bit) can be written at any time. The century bit inverts at the year wrap only while the enable is 1.
- R10: Day bit 6 is the test bit, and it resets to 0. When it is 1 and STOP is 0, bit 0 of a seconds read carries `test_tick`.
- R11: Bits that have no field read as 0: seconds bit 7 is STOP and bits 6:0 the value; minutes 6:0; hours 5:0; day bits 6, 5, 4 and 2:0; date 5:0; month 4:0; year 7:0.
- R12: After reset, control reads 0x00, seconds 0x80, minutes and hours 0x00, day 0x01, date 0x01, month 0x01 and year 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |
| sec_tick | input | 1 | One-cycle pulse per second |
| test_tick | input | 1 | 512 Hz square wave for the test output |
| trim_out | output | 6 | Stored trim value |

## Verification
The assertions check on every cycle that the counters stay in range after each step. They also check that a stopped chain does not move, that the century bit holds while its enable is 0, that frozen user copies stay still, and that reads outside the register window return zero. Only the bench scenarios can show the calendar results: month lengths, leap Februaries, the midnight and year wraps, the century toggle, the freeze release showing counts taken while frozen, and the load transfer. The test bit mux onto a seconds read is also shown only by the bench.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
   localparam int BYTE_W = 8;
   localparam int NREGS  = 8;
   localparam int IDX_W  = $clog2(NREGS);

   typedef struct packed {
      logic       cb;
      logic [7:0] yr;
      logic [4:0] mon;
      logic [5:0] date;
      logic [2:0] dow;
      logic [5:0] hr;
      logic [6:0] min;
      logic [6:0] sec;
   } rtc_time_t;

   localparam rtc_time_t TIME_RST = '{cb: 1'b0, yr: 8'h00, mon: 5'h01, date: 6'h01,
                                      dow: 3'd1, hr: 6'h00, min: 7'h00, sec: 7'h00};

   function automatic logic [7:0] bcd_inc(input logic [7:0] v);
      if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
      else                return v + 8'd1;
   endfunction

   function automatic logic is_leap(input logic [7:0] yr);
      if (yr[4]) return (yr[3:0] == 4'd2) || (yr[3:0] == 4'd6);
      else       return (yr[3:0] == 4'd0) || (yr[3:0] == 4'd4) || (yr[3:0] == 4'd8);
   endfunction

   function automatic logic [5:0] month_last(input logic [4:0] mon, input logic [7:0] yr);
      case (mon)
         5'h02:                      return is_leap(yr) ? 6'h29 : 6'h28;
         5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
         default:                    return 6'h31;
      endcase
   endfunction
endpackage

// File: rtl/rtc_counter.sv
module rtc_counter
   import rtc_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      step,
   input  logic      load,
   input  rtc_time_t ld_time,
   input  logic      cb_wr,
   input  logic      cb_val,
   input  logic      ceb,
   output rtc_time_t cur
);
   rtc_time_t nxt;
   logic [7:0] t_sec, t_min, t_hr, t_date, t_mon, t_yr;

   always_comb begin
      nxt    = cur;
      t_sec  = bcd_inc({1'b0, cur.sec});
      t_min  = bcd_inc({1'b0, cur.min});
      t_hr   = bcd_inc({2'b0, cur.hr});
      t_date = bcd_inc({2'b0, cur.date});
      t_mon  = bcd_inc({3'b0, cur.mon});
      t_yr   = bcd_inc(cur.yr);
      if (cur.sec != 7'h59) nxt.sec = t_sec[6:0];
      else begin
         nxt.sec = 7'h00;
         if (cur.min != 7'h59) nxt.min = t_min[6:0];
         else begin
            nxt.min = 7'h00;
            if (cur.hr != 6'h23) nxt.hr = t_hr[5:0];
            else begin
               nxt.hr  = 6'h00;
               nxt.dow = (cur.dow == 3'd7) ? 3'd1 : cur.dow + 3'd1;
               if (cur.date != month_last(cur.mon, cur.yr)) nxt.date = t_date[5:0];
               else begin
                  nxt.date = 6'h01;
                  if (cur.mon != 5'h12) nxt.mon = t_mon[4:0];
                  else begin
                     nxt.mon = 5'h01;
                     if (cur.yr != 8'h99) nxt.yr = t_yr;
                     else begin
                        nxt.yr = 8'h00;
                        nxt.cb = cur.cb ^ ceb;
                     end
                  end
               end
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cur <= TIME_RST;
      else if (load) cur <= ld_time;
      else begin
         if (step)  cur <= nxt;
         if (cb_wr) cur.cb <= cb_val;
      end
   end

   AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!step && !load && !cb_wr) |=> $stable(cur)); // R6
   AST_SEC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load) |=> (cur.sec <= 7'h59 && cur.min <= 7'h59)); // R7
   AST_HOUR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load) |=> (cur.hr <= 6'h23 && cur.dow >= 3'd1)); // R7
   AST_DATE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load) |=> (cur.date >= 6'h01 && cur.date <= month_last(cur.mon, cur.yr))); // R8
   AST_CB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!ceb && !load && !cb_wr) |=> $stable(cur.cb)); // R9
endmodule

// File: rtl/rtc_user_bank.sv
module rtc_user_bank
   import rtc_pkg::*;
#(
   parameter int ADDR_W      = 15,
   parameter bit FULL_DECODE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [BYTE_W-1:0] wdata,
   input  logic              we,
   input  logic              re,
   output logic [BYTE_W-1:0] rdata,
   input  logic              refresh_req,
   input  logic              test_tick,
   input  rtc_time_t         cnt,
   output rtc_time_t         usr,
   output logic              load,
   output logic              stop,
   output logic              ceb,
   output logic              cb_wr,
   output logic [5:0]        trim
);
   logic             hit;
   logic [IDX_W-1:0] idx;
   logic             ctl_w, ctl_r, ft, frz, wr_hit;
   logic [BYTE_W-1:0] mux;

   generate
      if (ADDR_W < IDX_W) begin : g_bad
         $error("ADDR_W too small for the register window");
      end
      if (FULL_DECODE) begin : g_full
         assign hit = &addr[ADDR_W-1:IDX_W];
      end else begin : g_part
         assign hit = 1'b1;
      end
   endgenerate

   assign idx    = addr[IDX_W-1:0];
   assign wr_hit = we && hit;
   assign frz    = ctl_w || ctl_r;
   assign load   = wr_hit && (idx == 3'd0) && ctl_w && !wdata[7];
   assign cb_wr  = wr_hit && (idx == 3'd4);

   always_comb begin
      case (idx)
         3'd0: mux = {ctl_w, ctl_r, trim};
         3'd1: mux = (ft && !stop) ? {stop, usr.sec[6:1], test_tick} : {stop, usr.sec};
         3'd2: mux = {1'b0, usr.min};
         3'd3: mux = {2'b0, usr.hr};
         3'd4: mux = {1'b0, ft, ceb, usr.cb, 1'b0, usr.dow};
         3'd5: mux = {2'b0, usr.date};
         3'd6: mux = {3'b0, usr.mon};
         default: mux = usr.yr;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         usr <= TIME_RST; ctl_w <= 1'b0; ctl_r <= 1'b0; trim <= '0;
         stop <= 1'b1; ft <= 1'b0; ceb <= 1'b0; rdata <= '0;
      end else begin
         if (refresh_req && !frz) usr <= cnt;
         if (wr_hit) begin
            case (idx)
               3'd0: {ctl_w, ctl_r, trim} <= wdata;
               3'd1: begin stop <= wdata[7]; usr.sec <= wdata[6:0]; end
               3'd2: usr.min <= wdata[6:0];
               3'd3: usr.hr  <= wdata[5:0];
               3'd4: begin ft <= wdata[6]; ceb <= wdata[5]; usr.cb <= wdata[4]; usr.dow <= wdata[2:0]; end
               3'd5: usr.date <= wdata[5:0];
               3'd6: usr.mon  <= wdata[4:0];
               default: usr.yr <= wdata;
            endcase
         end
         if (re) rdata <= hit ? mux : '0;
      end
   end

   AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (frz && !we) |=> ($stable(usr.sec) && $stable(usr.min) && $stable(usr.yr))); // R4
   AST_REFRESH_COPY: assert property (@(posedge clk) disable iff (!rst_n)
      (refresh_req && !frz && !we) |=> (usr.sec == $past(cnt.sec) && usr.date == $past(cnt.date))); // R3
   AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (re && !hit) |=> (rdata == 8'h00)); // R1
endmodule

// File: rtl/rtc_bcd_regs.sv
module rtc_bcd_regs
   import rtc_pkg::*;
#(
   parameter int ADDR_W      = 15,
   parameter bit FULL_DECODE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [7:0]        bus_wdata,
   input  logic              bus_we,
   input  logic              bus_re,
   output logic [7:0]        bus_rdata,
   input  logic              sec_tick,
   input  logic              test_tick,
   output logic [5:0]        trim_out
);
   rtc_time_t cnt, usr;
   logic      load, stop, ceb, cb_wr, tick_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tick_d <= 1'b0;
      else        tick_d <= sec_tick;
   end

   rtc_user_bank #(.ADDR_W(ADDR_W), .FULL_DECODE(FULL_DECODE)) u_bank (
      .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wdata(bus_wdata), .we(bus_we),
      .re(bus_re), .rdata(bus_rdata), .refresh_req(tick_d), .test_tick(test_tick),
      .cnt(cnt), .usr(usr), .load(load), .stop(stop), .ceb(ceb), .cb_wr(cb_wr),
      .trim(trim_out));

   rtc_counter u_cnt (
      .clk(clk), .rst_n(rst_n), .step(sec_tick && !stop), .load(load), .ld_time(usr),
      .cb_wr(cb_wr), .cb_val(bus_wdata[4]), .ceb(ceb), .cur(cnt));
endmodule

// File: tb/tb_rtc_bcd_regs.sv
module tb_rtc_bcd_regs;
   logic        clk = 0, rst_n = 0;
   logic [14:0] bus_addr = '0;
   logic [7:0]  bus_wdata = '0, bus_rdata;
   logic        bus_we = 0, bus_re = 0, sec_tick = 0, test_tick = 0;
   logic [5:0]  trim_out;
   int checks = 0, errors = 0, cyc = 0;
   logic [7:0] rv;

   always #10 clk = ~clk;

   rtc_bcd_regs dut (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata),
      .sec_tick(sec_tick), .test_tick(test_tick), .trim_out(trim_out));

   // in {yr,mon,date,dow,hr,min,sec}, out same order
   localparam logic [111:0] VEC [10] = '{
      {56'h99_12_31_07_23_59_59, 56'h00_01_01_01_00_00_00},
      {56'h24_06_15_03_12_34_56, 56'h24_06_15_03_12_34_57},
      {56'h23_02_28_02_23_59_59, 56'h23_03_01_03_00_00_00},
      {56'h24_02_28_04_23_59_59, 56'h24_02_29_05_00_00_00},
      {56'h00_02_29_05_23_59_59, 56'h00_03_01_06_00_00_00},
      {56'h21_04_30_01_23_59_59, 56'h21_05_01_02_00_00_00},
      {56'h21_05_30_01_23_59_59, 56'h21_05_31_02_00_00_00},
      {56'h21_07_04_06_09_59_59, 56'h21_07_04_06_10_00_00},
      {56'h21_07_04_06_19_09_59, 56'h21_07_04_06_19_10_00},
      {56'h19_09_30_06_23_59_59, 56'h19_10_01_07_00_00_00}};

   task automatic chk(input logic [7:0] got, input logic [7:0] exp, input string tag);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s actual %02h expected %02h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [2:0] r, input logic [7:0] d);
      @(negedge clk); bus_addr = {12'hFFF, r}; bus_wdata = d; bus_we = 1;
      @(negedge clk); bus_we = 0;
   endtask

   task automatic rd(input logic [14:0] a, output logic [7:0] d);
      @(negedge clk); bus_addr = a; bus_re = 1;
      @(negedge clk); bus_re = 0; d = bus_rdata;
   endtask

   task automatic rdr(input logic [2:0] r, input logic [7:0] exp, input string tag);
      logic [7:0] d;
      rd({12'hFFF, r}, d);
      chk(d, exp, tag);
   endtask

   task automatic tick();
      @(negedge clk); sec_tick = 1;
      @(negedge clk); sec_tick = 0;
      @(negedge clk);
   endtask

   task automatic load_time(input logic [55:0] t);
      wr(3'd0, 8'h80);
      for (int k = 1; k < 8; k++) wr(3'(k), t[8*(k-1) +: 8]);
      wr(3'd0, 8'h00);
   endtask

   task automatic finish_run();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 100000) begin
         checks++; errors++;
         $display("FAIL watchdog actual hung expected done");
         finish_run();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R12 reset state
      rdr(3'd0, 8'h00, "R12 control");
      rdr(3'd1, 8'h80, "R12 R6 seconds stop");
      rdr(3'd4, 8'h01, "R12 day");
      rdr(3'd5, 8'h01, "R12 date");
      rdr(3'd6, 8'h01, "R12 month");
      rdr(3'd7, 8'h00, "R12 year");
      chk({2'b0, trim_out}, 8'h00, "R12 trim");
      // R6 stop suspends counting
      tick();
      rdr(3'd1, 8'h80, "R6 stopped");
      wr(3'd1, 8'h00);
      tick();
      rdr(3'd1, 8'h01, "R6 R3 running");
      // R2 control fields
      wr(3'd0, 8'h25);
      rdr(3'd0, 8'h25, "R2 control readback");
      chk({2'b0, trim_out}, 8'h25, "R2 trim_out");
      wr(3'd0, 8'h00);
      // vector table: R1 order, R7 R8 rollover
      for (int i = 0; i < 10; i++) begin
         load_time(VEC[i][111:56]);
         tick();
         for (int k = 1; k < 8; k++)
            rdr(3'(k), VEC[i][8*(k-1) +: 8], $sformatf("R1 R7 R8 vec%0d reg%0d", i, k));
      end
      // R3 R4 freeze
      load_time(56'h21_01_01_01_12_00_00);
      tick();
      rdr(3'd1, 8'h01, "R3 refresh");
      wr(3'd0, 8'h40);
      tick(); tick(); tick();
      rdr(3'd1, 8'h01, "R4 frozen seconds");
      rdr(3'd2, 8'h00, "R4 frozen minutes");
      wr(3'd0, 8'h00);
      rdr(3'd1, 8'h01, "R4 no refresh before tick");
      tick();
      rdr(3'd1, 8'h05, "R4 counters kept running");
      // R5 load
      wr(3'd0, 8'h80);
      wr(3'd1, 8'h30);
      tick();
      rdr(3'd1, 8'h30, "R5 held during load");
      wr(3'd0, 8'h00);
      tick();
      rdr(3'd1, 8'h31, "R5 transferred");
      // R9 century toggle with enable
      load_time({56'h99_12_31_27_23_59_59});
      tick();
      rdr(3'd7, 8'h00, "R9 year wrap");
      rdr(3'd4, 8'h31, "R9 century toggled");
      load_time({56'h99_12_31_17_23_59_59});
      tick();
      rdr(3'd4, 8'h11, "R9 century held");
      wr(3'd4, 8'h01);
      tick();
      rdr(3'd4, 8'h01, "R9 direct century write");
      // R10 test output
      wr(3'd4, 8'h41);
      test_tick = 1;
      rd(15'h7FF9, rv); chk({7'b0, rv[0]}, 8'h01, "R10 test high");
      test_tick = 0;
      rd(15'h7FF9, rv); chk({7'b0, rv[0]}, 8'h00, "R10 test low");
      wr(3'd1, 8'h80);
      test_tick = 1;
      rdr(3'd1, 8'h80, "R10 stop masks test");
      test_tick = 0;
      wr(3'd4, 8'h01);
      // R11 unused bits, R1 miss
      wr(3'd3, 8'hFF);
      rdr(3'd3, 8'h3F, "R11 hours mask");
      wr(3'd6, 8'hFF);
      rdr(3'd6, 8'h1F, "R11 month mask");
      wr(3'd2, 8'hFF);
      rdr(3'd2, 8'h7F, "R11 minutes mask");
      rd(15'h7FF7, rv); chk(rv, 8'h00, "R1 below window");
      rd(15'h0123, rv); chk(rv, 8'h00, "R1 low address");
      finish_run();
   end
endmodule